// File: doc/BRIEF.md
# Transceiver Reset Sequencing Controller

This block is a synchronous state machine that brings a group of serial transceiver channels out of power-down and reset in a fixed order. The receiver clock-data recovery in these channels runs in automatic lock mode. The block watches four status flags: calibration busy, PLL locked, reconfiguration done and receiver frequency locked. From them it drives a block-wide power-down, a PLL power-down, the transmitter digital reset, the receiver analog reset, the receiver digital reset and a ready flag. Every timed interval is a parameter counted in clock cycles. The power-down pulse width is worked out from the clock frequency and a minimum width in nanoseconds.

The states are as follows. `WAIT_CAL` holds everything in reset until calibration finishes. `BLK_PD` drives the block power-down pulse. `PLL_WAIT` releases the PLL power-down and waits for lock. `RECFG_WAIT` waits for reconfiguration to finish. `ANA_HOLD` releases the transmitter and keeps the receiver analog reset high for a fixed number of cycles. `FLOCK_WAIT` waits for frequency lock. `LTD_WAIT` counts the lock-time interval. `DIG_REL` releases the receiver digital reset. `READY` signals that the receiver can take traffic.

The forward transitions run in that order. There are also two recovery transitions. A drop of PLL lock in any state from `RECFG_WAIT` onward goes back to `PLL_WAIT`. A drop of frequency lock in `LTD_WAIT`, `DIG_REL` or `READY` goes back to `ANA_HOLD`. While calibration busy is high, the machine makes no transition and its timer does not advance.

Top module: `xcvr_rst_seq`

## Requirements
- R1: During and right after reset, the outputs are: `blk_pd`=0, `pll_pd`=1, `tx_dig_rst`=1, `rx_ana_rst`=1, `rx_dig_rst`=1, `rx_ready`=0.
- R2: `blk_pd` does not rise while `cal_busy` is high. It rises one clock after the first cycle in which `cal_busy` is sampled low.
- R3: In any cycle where `cal_busy` is sampled high, no output changes on the following edge, and the interval timers hold their count.
- R4: `blk_pd` stays high for exactly PD_CYC = ceil(CLK_MHZ*PD_NS/1000) clock cycles in which busy is low. Cycles frozen by busy add to the width.
- R5: `pll_pd` falls on the same edge that `blk_pd` falls. Until PLL lock is seen, `tx_dig_rst` stays high.
- R6: Once PLL lock is held, `tx_dig_rst` falls one clock after `rcfg_done` is sampled high, and not before.
- R7: After `tx_dig_rst` falls, `rx_ana_rst` stays high for exactly ANA_CYC clock cycles.
- R8: After `rx_ana_rst` is released, `rx_dig_rst` falls LTD_CYC+1 clocks after `rx_flock` is first sampled high, provided lock holds throughout.
- R9: If `rx_flock` drops during the lock-time wait or after it, the next edge raises `rx_ana_rst` and `rx_dig_rst` again and clears `rx_ready`. The analog hold and the lock-time count then restart from zero.
- R10: If `pll_locked` drops in any state after `PLL_WAIT`, the next edge raises `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` and clears `rx_ready`. The sequence then continues from waiting for PLL lock.
- R11: `rx_ready` rises exactly one clock after `rx_dig_rst` falls and stays high until a lock is lost or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_busy | input | 1 | Receiver offset calibration in progress |
| pll_locked | input | 1 | Transmit PLL locked |
| rcfg_done | input | 1 | Channel reconfiguration finished |
| rx_flock | input | 1 | Receiver CDR frequency locked |
| blk_pd | output | 1 | Power-down of the whole transceiver group |
| pll_pd | output | 1 | PLL power-down |
| tx_dig_rst | output | 1 | Transmitter digital reset |
| rx_ana_rst | output | 1 | Receiver analog reset |
| rx_dig_rst | output | 1 | Receiver digital reset |
| rx_ready | output | 1 | Receiver ready for traffic |

## Verification
The bench measures the width of the power-down pulse once with no busy and once with busy raised in the middle of the pulse. A design that ignored busy there would end the pulse seven cycles early. It counts the analog hold and the lock-time wait to the exact cycle, so an off-by-one timer or a `rx_ready` that rises together with the digital reset release is caught. It drops frequency lock partway through the lock-time wait and then checks that the full interval is timed again; a counter that only paused instead of restarting would release the digital reset too soon. It also removes PLL lock and then frequency lock after ready. A design that kept the receiver released or missed the transmitter reset would show up at the outputs on the very next cycle.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [3:0] {
        WAIT_CAL   = 4'd0,
        BLK_PD     = 4'd1,
        PLL_WAIT   = 4'd2,
        RECFG_WAIT = 4'd3,
        ANA_HOLD   = 4'd4,
        FLOCK_WAIT = 4'd5,
        LTD_WAIT   = 4'd6,
        DIG_REL    = 4'd7,
        READY      = 4'd8
    } xrs_state_e;

    typedef struct packed {
        logic blk_pd;
        logic pll_pd;
        logic tx_rst;
        logic rx_ana;
        logic rx_dig;
        logic ready;
    } xrs_out_t;

    localparam xrs_out_t XRS_RESET_OUT = '{blk_pd: 1'b0, pll_pd: 1'b1, tx_rst: 1'b1,
                                           rx_ana: 1'b1, rx_dig: 1'b1, ready: 1'b0};

endpackage

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int MAX_CNT = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         en,
    output logic [$clog2(MAX_CNT+1)-1:0] cnt
);
    localparam int CW = $clog2(MAX_CNT + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: when the timer is not enabled and not cleared, its count holds
    p_hold_when_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    // R4: the count never passes its ceiling
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
endmodule

// File: rtl/xrs_outdec.sv
module xrs_outdec
    import xrs_pkg::*;
(
    input  xrs_state_e st,
    output xrs_out_t   o
);
    always_comb begin
        o = XRS_RESET_OUT;
        unique case (st)
            WAIT_CAL:   o = XRS_RESET_OUT;
            BLK_PD:     o.blk_pd = 1'b1;
            PLL_WAIT,
            RECFG_WAIT: o.pll_pd = 1'b0;
            ANA_HOLD: begin
                o.pll_pd = 1'b0;
                o.tx_rst = 1'b0;
            end
            FLOCK_WAIT,
            LTD_WAIT: begin
                o.pll_pd = 1'b0;
                o.tx_rst = 1'b0;
                o.rx_ana = 1'b0;
            end
            DIG_REL: begin
                o.pll_pd = 1'b0;
                o.tx_rst = 1'b0;
                o.rx_ana = 1'b0;
                o.rx_dig = 1'b0;
            end
            READY: begin
                o.pll_pd = 1'b0;
                o.tx_rst = 1'b0;
                o.rx_ana = 1'b0;
                o.rx_dig = 1'b0;
                o.ready  = 1'b1;
            end
            default:    o = XRS_RESET_OUT;
        endcase
    end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int CLK_MHZ = 125,
    parameter int PD_NS   = 1000,
    parameter int ANA_CYC = 5,
    parameter int LTD_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_busy,
    input  logic pll_locked,
    input  logic rcfg_done,
    input  logic rx_flock,
    output logic blk_pd,
    output logic pll_pd,
    output logic tx_dig_rst,
    output logic rx_ana_rst,
    output logic rx_dig_rst,
    output logic rx_ready
);
    localparam int PD_CYC  = (CLK_MHZ * PD_NS + 999) / 1000;
    localparam int MAX_A   = (PD_CYC > ANA_CYC) ? PD_CYC : ANA_CYC;
    localparam int MAX_CYC = (MAX_A > LTD_CYC) ? MAX_A : LTD_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] PD_LAST  = CW'(PD_CYC - 1);
    localparam logic [CW-1:0] ANA_LAST = CW'(ANA_CYC - 1);
    localparam logic [CW-1:0] LTD_LAST = CW'(LTD_CYC - 1);

    xrs_state_e    st, st_nxt;
    xrs_out_t      out_nxt, out_q;
    logic [CW-1:0] cnt;
    logic          tmr_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= WAIT_CAL;
        end else begin
            st <= st_nxt;
        end
    end

    // Next-state logic; busy freezes every transition
    always_comb begin
        st_nxt = st;
        if (!cal_busy) begin
            unique case (st)
                WAIT_CAL:   st_nxt = BLK_PD;
                BLK_PD:     if (cnt == PD_LAST) st_nxt = PLL_WAIT;
                PLL_WAIT:   if (pll_locked) st_nxt = RECFG_WAIT;
                RECFG_WAIT: begin
                    if (!pll_locked)    st_nxt = PLL_WAIT;
                    else if (rcfg_done) st_nxt = ANA_HOLD;
                end
                ANA_HOLD: begin
                    if (!pll_locked)          st_nxt = PLL_WAIT;
                    else if (cnt == ANA_LAST) st_nxt = FLOCK_WAIT;
                end
                FLOCK_WAIT: begin
                    if (!pll_locked)   st_nxt = PLL_WAIT;
                    else if (rx_flock) st_nxt = LTD_WAIT;
                end
                LTD_WAIT: begin
                    if (!pll_locked)          st_nxt = PLL_WAIT;
                    else if (!rx_flock)       st_nxt = ANA_HOLD;
                    else if (cnt == LTD_LAST) st_nxt = DIG_REL;
                end
                DIG_REL, READY: begin
                    if (!pll_locked)    st_nxt = PLL_WAIT;
                    else if (!rx_flock) st_nxt = ANA_HOLD;
                    else                st_nxt = READY;
                end
                default: st_nxt = WAIT_CAL;
            endcase
        end
    end

    assign tmr_clr = (st_nxt != st);

    xrs_timer #(.MAX_CNT(MAX_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (!cal_busy),
        .cnt   (cnt)
    );

    xrs_outdec u_dec (
        .st (st_nxt),
        .o  (out_nxt)
    );

    // Output register, loaded from the decode of the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= XRS_RESET_OUT;
        end else begin
            out_q <= out_nxt;
        end
    end

    assign blk_pd     = out_q.blk_pd;
    assign pll_pd     = out_q.pll_pd;
    assign tx_dig_rst = out_q.tx_rst;
    assign rx_ana_rst = out_q.rx_ana;
    assign rx_dig_rst = out_q.rx_dig;
    assign rx_ready   = out_q.ready;

    p_pd_after_cal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_pd) |-> !$past(cal_busy));

    p_busy_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |=> $stable(out_q));

    p_pll_pd_during_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_pd |-> pll_pd);

    p_tx_before_ana_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ana_rst |-> !tx_dig_rst);

    p_ana_before_dig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dig_rst |-> !rx_ana_rst);

    p_pll_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_dig_rst && !pll_locked && !cal_busy) |=> (tx_dig_rst && !rx_ready));

    p_ready_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_dig_rst) && !cal_busy && pll_locked && rx_flock) |=> rx_ready);

    p_ready_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (!rx_dig_rst && !rx_ana_rst && !tx_dig_rst && !pll_pd && !blk_pd));
endmodule

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb;
    localparam int CLK_MHZ = 125;
    localparam int PD_NS   = 1000;
    localparam int ANA_CYC = 5;
    localparam int LTD_CYC = 20;
    localparam int PD_CYC  = (CLK_MHZ * PD_NS + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_busy = 1'b1;
    logic pll_locked = 1'b0;
    logic rcfg_done = 1'b0;
    logic rx_flock = 1'b0;
    logic blk_pd, pll_pd, tx_dig_rst, rx_ana_rst, rx_dig_rst, rx_ready;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    xcvr_rst_seq #(.CLK_MHZ(CLK_MHZ), .PD_NS(PD_NS), .ANA_CYC(ANA_CYC), .LTD_CYC(LTD_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy), .pll_locked(pll_locked),
        .rcfg_done(rcfg_done), .rx_flock(rx_flock), .blk_pd(blk_pd), .pll_pd(pll_pd),
        .tx_dig_rst(tx_dig_rst), .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
        .rx_ready(rx_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        cal_busy = 1'b1; pll_locked = 1'b0; rcfg_done = 1'b0; rx_flock = 1'b0;
        rst_n = 1'b0;
        step(3);
        chk("R1 outputs in reset", {blk_pd, pll_pd, tx_dig_rst, rx_ana_rst, rx_dig_rst, rx_ready}, 6'b011110);
        rst_n = 1'b1;
        step(1);
        chk("R1 outputs after reset", {blk_pd, pll_pd, tx_dig_rst, rx_ana_rst, rx_dig_rst, rx_ready}, 6'b011110);
        step(10);
        chk("R2 no power-down while busy", int'(blk_pd), 0);
    endtask

    // Drop busy, measure the power-down pulse; optionally raise busy mid-pulse for k cycles
    task automatic t_pulse(input int k);
        int width = 0;
        int hold = 0;
        cal_busy = 1'b0;
        step(1);
        chk("R2 power-down one clock after busy low", int'(blk_pd), 1);
        for (int i = 0; i < 2000; i++) begin
            if (!blk_pd) break;
            width++;
            if (hold > 0) begin
                hold--;
                if (hold == 0) cal_busy = 1'b0;
            end else if (width == 20 && k > 0) begin
                cal_busy = 1'b1;
                hold = k;
            end
            step(1);
        end
        chk(k > 0 ? "R3 R4 pulse width with busy freeze" : "R4 pulse width", width, PD_CYC + k);
        chk("R5 pll power-down released with pulse end", int'(pll_pd), 0);
        chk("R5 tx reset held before pll lock", int'(tx_dig_rst), 1);
    endtask

    task automatic t_pll_recfg();
        step(8);
        chk("R5 tx reset held without pll lock", int'(tx_dig_rst), 1);
        pll_locked = 1'b1;
        step(5);
        chk("R6 tx reset held without reconfig done", int'(tx_dig_rst), 1);
        rcfg_done = 1'b1;
        step(1);
        chk("R6 tx reset released after reconfig done", int'(tx_dig_rst), 0);
        begin
            int w = 0;
            for (int i = 0; i < 100; i++) begin
                if (!rx_ana_rst) break;
                w++;
                step(1);
            end
            chk("R7 analog reset hold length", w, ANA_CYC);
        end
    endtask

    // Raise frequency lock; if drop_at > 0, remove it partway and relock
    task automatic t_lock(input int drop_at);
        int n = 0;
        step(6);
        chk("R8 digital reset held without freq lock", int'(rx_dig_rst), 1);
        rx_flock = 1'b1;
        if (drop_at > 0) begin
            step(drop_at);
            rx_flock = 1'b0;
            step(1);
            chk("R9 analog reset reasserted on freq loss", int'(rx_ana_rst), 1);
            chk("R9 digital reset still held on freq loss", int'(rx_dig_rst), 1);
            step(ANA_CYC + 3);
            chk("R9 analog reset released again", int'(rx_ana_rst), 0);
            rx_flock = 1'b1;
        end
        for (int i = 0; i < 1000; i++) begin
            step(1);
            n++;
            if (!rx_dig_rst) break;
        end
        chk("R8 digital reset release delay", n, LTD_CYC + 1);
        chk("R11 ready low on release cycle", int'(rx_ready), 0);
        step(1);
        chk("R11 ready one clock after release", int'(rx_ready), 1);
        step(10);
        chk("R11 ready stays high", int'(rx_ready), 1);
    endtask

    task automatic t_freq_loss();
        rx_flock = 1'b0;
        step(1);
        chk("R9 ready dropped on freq loss", int'(rx_ready), 0);
        chk("R9 analog reset on freq loss after ready", int'(rx_ana_rst), 1);
        chk("R9 tx stays released on freq loss", int'(tx_dig_rst), 0);
        step(ANA_CYC + 2);
        rx_flock = 1'b1;
        step(LTD_CYC + 3);
        chk("R9 ready regained after relock", int'(rx_ready), 1);
    endtask

    task automatic t_pll_loss();
        pll_locked = 1'b0;
        step(1);
        chk("R10 tx reset reasserted on pll loss", int'(tx_dig_rst), 1);
        chk("R10 ready dropped on pll loss", int'(rx_ready), 0);
        chk("R10 receiver resets reasserted", {rx_ana_rst, rx_dig_rst}, 2'b11);
        step(4);
        chk("R10 held while pll unlocked", int'(tx_dig_rst), 1);
        pll_locked = 1'b1;
        step(1);
        chk("R10 tx still held one clock after relock", int'(tx_dig_rst), 1);
        step(1);
        chk("R10 tx released after relock", int'(tx_dig_rst), 0);
        step(ANA_CYC + LTD_CYC + 4);
        chk("R10 ready regained after pll relock", int'(rx_ready), 1);
    endtask

    task automatic t_busy_late();
        cal_busy = 1'b1;
        rx_flock = 1'b0;
        step(6);
        chk("R3 outputs frozen while busy", {rx_ready, rx_ana_rst}, 2'b10);
        cal_busy = 1'b0;
        step(1);
        chk("R3 freq loss acted on after busy", {rx_ready, rx_ana_rst}, 2'b01);
        rx_flock = 1'b1;
    endtask

    initial begin
        t_reset();
        t_pulse(0);
        t_pll_recfg();
        t_lock(7);
        t_freq_loss();
        t_pll_loss();
        t_busy_late();
        t_reset();
        t_pulse(7);
        t_pll_recfg();
        t_lock(0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule